// File: doc/BRIEF.md
# LIN Transceiver Mode Sequencer

This block is the digital mode controller of a LIN physical-layer interface. It walks the interface through five modes: power-on reset, Ready, Operation, Transmitter Off and Power-Down. It decides which analog sections are powered: the external regulator enable, the receiver, the bus driver and the bus pull-up. It also gates the transmit data that reaches the driver. Supply health, faults and remote bus wake events come in as digital flags from neighbouring blocks.

The host drives the chip-select pin. A debounce counter filters it before any mode decision uses it. When the filtered select rises in Ready, the levels of transmit data and transmit enable pick the next mode. A high on both gives Operation; anything else gives Transmitter Off. Transmitter Off releases back to Operation only when select, transmit data and transmit enable are all high and no fault is present. Once select goes low, the block sleeps in Power-Down. Three events wake it back to Ready: select high, a falling edge on the local wake pin, or a bus wake request.

Top module: `lin_mode_ctrl`

## Requirements
- R1: Synchronous reset puts the block in power-on reset (mode code 0) with every enable low and `txd_drv` high. A low `supply_ok` in any mode returns the block to power-on reset on the next clock edge.
- R2: From power-on reset the block enters Ready (code 1) on the STABLE_CYCLES-th consecutive clock edge with `supply_ok` high.
- R3: In Ready with filtered chip select high, the next edge enters Operation (code 2) when `txd_in` and `txe_in` are both 1. Otherwise it enters Transmitter Off (code 3).
- R4: In Operation with filtered chip select high, an active `fault` or a low `txe_in` moves the block to Transmitter Off on the next edge.
- R5: Transmitter Off moves to Operation only when filtered chip select, `txd_in` and `txe_in` are all 1 and `fault` is 0. In every other case it stays in Transmitter Off or goes to Power-Down.
- R6: In Operation or Transmitter Off, a low filtered chip select moves the block to Power-Down (code 4) on the next edge.
- R7: Power-Down goes to Ready on the next edge after any of these: filtered chip select high, `wake_pin` sampled 1 then 0 on consecutive edges, or `bus_wake` high.
- R8: A change on `cs_pin` reaches the filtered select only after it has been held for FILT_CYCLES consecutive edges. The mode can therefore change no earlier than FILT_CYCLES+1 edges after the pin moves. Shorter pulses have no effect.
- R9: `reg_en` and `rx_en` are 1 in Ready, Operation and Transmitter Off. `tx_en` and `pullup_en` are 1 only in Operation. `txd_drv` equals `txd_in` in Operation and is 1 in every other mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| supply_ok | input | 1 | Battery supply above minimum |
| cs_pin | input | 1 | Chip select from host; undriven reads as low |
| txd_in | input | 1 | Transmit data from host, 0 = dominant |
| txe_in | input | 1 | Transmit enable, low forces the driver off |
| fault | input | 1 | Summary of thermal, contention and timeout faults |
| wake_pin | input | 1 | Local wake input, falling edge wakes |
| bus_wake | input | 1 | Wake request from the bus activity detector |
| reg_en | output | 1 | Regulator enable |
| rx_en | output | 1 | Receiver enable |
| tx_en | output | 1 | Bus driver enable |
| pullup_en | output | 1 | Bus pull-up enable |
| txd_drv | output | 1 | Gated transmit data to the driver |
| mode | output | 3 | Current mode code |

## Verification
The assertions assume that every input is already synchronous to `clk` and is stable around the rising edge. They also assume that `rst` is high from time zero until the first edges have passed. The bench changes inputs only on falling edges. It holds `rst` high for several cycles before releasing it. The random phase drops `supply_ok`, moves `cs_pin` and pulses the wake inputs at low rates. This lets filter windows both complete and get cut short, without making the stimulus more synchronous than a real host would be.

// File: rtl/lin_mode_ctrl.sv
module lin_mode_ctrl #(
  parameter int FILT_CYCLES   = 2000,
  parameter int STABLE_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       supply_ok,
  input  logic       cs_pin,
  input  logic       txd_in,
  input  logic       txe_in,
  input  logic       fault,
  input  logic       wake_pin,
  input  logic       bus_wake,
  output logic       reg_en,
  output logic       rx_en,
  output logic       tx_en,
  output logic       pullup_en,
  output logic       txd_drv,
  output logic [2:0] mode
);

  localparam logic [2:0] M_POR = 3'd0;
  localparam logic [2:0] M_RDY = 3'd1;
  localparam logic [2:0] M_OPR = 3'd2;
  localparam logic [2:0] M_TOF = 3'd3;
  localparam logic [2:0] M_PDN = 3'd4;
  localparam int FW = $clog2(FILT_CYCLES + 1);
  localparam int SW = $clog2(STABLE_CYCLES + 1);

  logic [2:0]    st, nx;
  logic          cs_f;
  logic [FW-1:0] fcnt;
  logic [SW-1:0] scnt;
  logic          wake_q;

  wire cs_hi     = (cs_pin === 1'b1);
  wire wake_fall = wake_q & ~wake_pin;
  wire stab_done = (scnt == SW'(STABLE_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_f <= 1'b0;
      fcnt <= '0;
    end else if (cs_hi != cs_f) begin
      if (fcnt == FW'(FILT_CYCLES - 1)) begin
        cs_f <= cs_hi;
        fcnt <= '0;
      end else begin
        fcnt <= fcnt + 1'b1;
      end
    end else begin
      fcnt <= '0;
    end
  end

  always_comb begin
    nx = st;
    if (!supply_ok) nx = M_POR;
    else begin
      case (st)
        M_POR: if (stab_done) nx = M_RDY;
        M_RDY: if (cs_f) nx = (txd_in && txe_in) ? M_OPR : M_TOF;
        M_OPR: if (!cs_f) nx = M_PDN;
               else if (fault || !txe_in) nx = M_TOF;
        M_TOF: if (!cs_f) nx = M_PDN;
               else if (txd_in && txe_in && !fault) nx = M_OPR;
        M_PDN: if (cs_f || wake_fall || bus_wake) nx = M_RDY;
        default: nx = M_POR;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= M_POR;
      scnt   <= '0;
      wake_q <= 1'b1;
    end else begin
      st     <= nx;
      scnt   <= (st == M_POR && supply_ok && !stab_done) ? scnt + 1'b1 : '0;
      wake_q <= wake_pin;
    end
  end

  assign reg_en    = (st == M_RDY) || (st == M_OPR) || (st == M_TOF);
  assign rx_en     = reg_en;
  assign tx_en     = (st == M_OPR);
  assign pullup_en = tx_en;
  assign txd_drv   = tx_en ? txd_in : 1'b1;
  assign mode      = st;

  AST_SUPPLY_LOSS: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> mode == M_POR); // R1
  AST_FAULT_OFF: assert property (@(posedge clk) disable iff (rst)
    (mode == M_OPR && cs_f && supply_ok && (fault || !txe_in)) |=> mode == M_TOF); // R4
  AST_TOF_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mode == M_TOF && (!cs_f || fault || !txe_in || !txd_in)) |=> mode != M_OPR); // R5
  AST_SLEEP: assert property (@(posedge clk) disable iff (rst)
    ((mode == M_OPR || mode == M_TOF) && !cs_f && supply_ok) |=> mode == M_PDN); // R6
  AST_BUS_WAKE: assert property (@(posedge clk) disable iff (rst)
    (mode == M_PDN && bus_wake && supply_ok) |=> mode == M_RDY); // R7
  AST_CS_FILTER: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && cs_f != $past(cs_f)) |-> cs_f == $past(cs_hi)); // R8
  AST_DRV_IDLE: assert property (@(posedge clk) disable iff (rst)
    (mode != M_OPR) |-> (txd_drv && !pullup_en)); // R9

endmodule

// File: tb/sim_lin_mode_ctrl.sv
`timescale 1ns/1ps
module sim_lin_mode_ctrl;
  localparam int FILT = 4;
  localparam int STAB = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply_ok = 1'b0, cs_pin = 1'b0, txd_in = 1'b1, txe_in = 1'b1;
  logic fault = 1'b0, wake_pin = 1'b1, bus_wake = 1'b0;
  logic reg_en, rx_en, tx_en, pullup_en, txd_drv;
  logic [2:0] mode;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  lin_mode_ctrl #(.FILT_CYCLES(FILT), .STABLE_CYCLES(STAB)) u0 (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .cs_pin(cs_pin), .txd_in(txd_in),
    .txe_in(txe_in), .fault(fault), .wake_pin(wake_pin), .bus_wake(bus_wake),
    .reg_en(reg_en), .rx_en(rx_en), .tx_en(tx_en), .pullup_en(pullup_en),
    .txd_drv(txd_drv), .mode(mode));

  // reference model built from the requirements
  logic [2:0] m_mode;
  logic       m_csf, m_wq;
  int         m_fc, m_sc;

  function automatic logic [2:0] f_next(input logic [2:0] cur, input logic sup,
      input logic csf, input logic td, input logic te, input logic flt,
      input logic wf, input logic bw, input logic sdone);
    if (!sup) return 3'd0;
    case (cur)
      3'd0: return sdone ? 3'd1 : 3'd0;
      3'd1: return csf ? ((td && te) ? 3'd2 : 3'd3) : 3'd1;
      3'd2: return !csf ? 3'd4 : ((flt || !te) ? 3'd3 : 3'd2);
      3'd3: return !csf ? 3'd4 : ((td && te && !flt) ? 3'd2 : 3'd3);
      3'd4: return (csf || wf || bw) ? 3'd1 : 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [4:0] f_outs(input logic [2:0] md, input logic td);
    logic on, op;
    on = (md == 3'd1) || (md == 3'd2) || (md == 3'd3);
    op = (md == 3'd2);
    return {on, on, op, op, op ? td : 1'b1};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_mode <= 3'd0; m_csf <= 1'b0; m_fc <= 0; m_sc <= 0; m_wq <= 1'b1;
    end else begin
      m_wq <= wake_pin;
      if (cs_pin != m_csf) begin
        if (m_fc == FILT - 1) begin m_csf <= cs_pin; m_fc <= 0; end
        else m_fc <= m_fc + 1;
      end else m_fc <= 0;
      m_sc <= (m_mode == 3'd0 && supply_ok && m_sc != STAB - 1) ? m_sc + 1 : 0;
      m_mode <= f_next(m_mode, supply_ok, m_csf, txd_in, txe_in, fault,
                       m_wq & ~wake_pin, bus_wake, m_sc == STAB - 1);
    end
  end

  task automatic chk(input int act, input int exp, input string req);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    tick(4);
    chk(mode, 0, "R1 reset mode");
    chk({reg_en, rx_en, tx_en, pullup_en, txd_drv}, 5'b00001, "R1 reset outputs");
    rst = 1'b0; supply_ok = 1'b1;
    tick(STAB - 1);
    chk(mode, 0, "R2 still stabilising");
    tick(1);
    chk(mode, 1, "R2 ready");
    chk({reg_en, rx_en, tx_en, pullup_en}, 4'b1100, "R9 ready outputs");
    cs_pin = 1'b1;
    tick(FILT);
    chk(mode, 1, "R8 filter delay");
    tick(1);
    chk(mode, 2, "R3 ready to operation");
    txd_in = 1'b0; #1;
    chk({tx_en, pullup_en, txd_drv}, 3'b110, "R9 operation drives txd");
    fault = 1'b1;
    tick(1);
    chk(mode, 3, "R4 fault to txoff");
    chk({tx_en, pullup_en, txd_drv}, 3'b001, "R9 txoff recessive");
    fault = 1'b0;
    tick(1);
    chk(mode, 3, "R5 txd low holds txoff");
    txd_in = 1'b1; txe_in = 1'b0;
    tick(1);
    chk(mode, 3, "R5 txe low holds txoff");
    txe_in = 1'b1; fault = 1'b1;
    tick(1);
    chk(mode, 3, "R5 fault holds txoff");
    fault = 1'b0;
    tick(1);
    chk(mode, 2, "R5 release to operation");
    txe_in = 1'b0;
    tick(1);
    chk(mode, 3, "R4 txe low to txoff");
    txe_in = 1'b1;
    tick(1);
    chk(mode, 2, "R5 release again");
    cs_pin = 1'b0;
    tick(FILT - 1);
    cs_pin = 1'b1;
    tick(FILT);
    chk(mode, 2, "R8 short cs pulse ignored");
    cs_pin = 1'b0;
    tick(FILT);
    chk(mode, 2, "R8 low not yet filtered");
    tick(1);
    chk(mode, 4, "R6 operation to powerdown");
    chk({reg_en, rx_en, tx_en, pullup_en, txd_drv}, 5'b00001, "R9 powerdown outputs");
    wake_pin = 1'b0;
    tick(1);
    chk(mode, 1, "R7 local wake edge");
    wake_pin = 1'b1;
    tick(3);
    chk(mode, 1, "R7 ready holds with cs low");
    txd_in = 1'b0; cs_pin = 1'b1;
    tick(FILT + 1);
    chk(mode, 3, "R3 ready to txoff on txd low");
    cs_pin = 1'b0;
    tick(FILT + 1);
    chk(mode, 4, "R6 txoff to powerdown");
    bus_wake = 1'b1;
    tick(1);
    chk(mode, 1, "R7 bus wake");
    bus_wake = 1'b0; txd_in = 1'b1;
    supply_ok = 1'b0;
    tick(1);
    chk(mode, 0, "R1 supply loss");
    chk({reg_en, rx_en, tx_en, pullup_en, txd_drv}, 5'b00001, "R1 supply loss outputs");
    supply_ok = 1'b1;

    for (int i = 0; i < 5000; i++) begin
      tick(1);
      chk(mode, m_mode, "R3 R4 R5 R6 R7 model mode");
      chk({reg_en, rx_en, tx_en, pullup_en, txd_drv}, f_outs(m_mode, txd_in), "R9 model outputs");
      supply_ok = ($urandom % 300 == 0) ? 1'b0 : 1'b1;
      if ($urandom % 12 == 0) cs_pin = ~cs_pin;
      txd_in   = ($urandom % 4) != 0;
      txe_in   = ($urandom % 8) != 0;
      fault    = ($urandom % 16) == 0;
      if ($urandom % 10 == 0) wake_pin = ~wake_pin;
      bus_wake = ($urandom % 30) == 0;
    end
    tick(1);
    chk(mode, m_mode, "R8 final model mode");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule